// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a processor. Each request is captured into a pending register, either on a rising edge or by following the line level, chosen per input. Pending requests pass through a mask and into a fixed-priority resolver, where input 0 ranks highest and input 7 lowest. An in-service register records which levels the processor is handling now. A pending request raises the interrupt output only if it outranks every level already in service.

The processor reaches the block over an 8-bit bus. The bus is qualified by an active-low chip select and separate active-low read and write strobes, and a 2-bit address selects the register. When the processor acknowledges, the winning request moves from pending to in-service and the block drives a vector byte onto the read data. The processor ends service by writing an end-of-interrupt command. That command retires the highest-priority level in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, int_out is low, the pending and in-service registers read 8'h00, the mask reads 8'hFF, the trigger-mode register reads 8'h00 (all edge mode) and the vector base is zero.
- R2: In edge mode (mode bit 0) a low-to-high transition on an input sets its pending bit, and the bit stays set after the input falls. A line held high after its grant raises no new request.
- R3: In level mode (mode bit 1) the pending bit follows the input each cycle, so dropping the input withdraws the request.
- R4: A mask bit of 1 still lets its input's pending bit be set, but keeps that request from raising int_out. Clearing the mask bit lets the request raise int_out.
- R5: Among unmasked pending requests the lowest input index wins.
- R6: While inta is high and int_out is high, data_out carries {base[7:3], winner index[2:0]} with data_oe high. At the next edge the winner's in-service bit is set and its pending bit is cleared.
- R7: int_out is high only when the winner's index is lower than the lowest index set in the in-service register, or when that register is empty.
- R8: A write to address 2 (end of interrupt, data ignored) clears the lowest-index bit set in the in-service register.
- R9: Writes take effect once, in the first cycle that cs_n and wr_n are both low. Address 0 writes the mask, address 1 writes the vector base from data bits 7:3, and address 3 writes the trigger mode (bit i set = level for input i). Reads with cs_n and rd_n low return pending (0), in-service (1), mask (2) or mode (3). With cs_n high, neither a write nor a read has any effect.
- R10: An acknowledge while int_out is low returns {base, 3'b111} and changes no register.
- R11: In edge mode, a new rising edge on an input in the same cycle that input is granted leaves its pending bit set after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 8 | Interrupt request lines, index 0 highest priority |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data or acknowledge vector |
| data_oe | output | 1 | High while data_out is being driven |
| inta | input | 1 | Acknowledge, active high, one cycle per grant |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall in the same clock cycle. A grant can clear a pending bit while a fresh rising edge on the same input tries to set it. An end-of-interrupt can also meet a grant, both updating the in-service register. The bench drives the input edge in the very cycle that inta is high and then reads back both registers: pending must still hold the new request and in-service must hold the granted level. A long write strobe on the end-of-interrupt address with two levels in service must clear exactly one of them.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM = 8,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NUM-1:0] irq,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          inta,
  output logic          int_out
);
  localparam int unsigned IW = $clog2(NUM);
  localparam int unsigned BW = DW - IW;

  logic [NUM-1:0] irr, isr, mask, mode, irq_q;
  logic [BW-1:0]  base;
  logic           wr_q;
  logic [IW-1:0]  win_idx, srv_idx;
  logic           win_vld, srv_vld;

  wire            wr_act  = ~cs_n & ~wr_n;
  wire            wr_stb  = wr_act & ~wr_q;
  wire            rd_act  = ~cs_n & ~rd_n;
  wire            eoi_stb = wr_stb && addr == 2'd2;
  wire [NUM-1:0]  pend    = irr & ~mask;
  wire [NUM-1:0]  rise    = irq & ~irq_q;

  always_comb begin
    win_idx = '0;
    win_vld = 1'b0;
    for (int i = NUM - 1; i >= 0; i--)
      if (pend[i]) begin
        win_idx = IW'(i);
        win_vld = 1'b1;
      end
  end

  always_comb begin
    srv_idx = '0;
    srv_vld = 1'b0;
    for (int i = NUM - 1; i >= 0; i--)
      if (isr[i]) begin
        srv_idx = IW'(i);
        srv_vld = 1'b1;
      end
  end

  assign int_out = win_vld && (!srv_vld || win_idx < srv_idx);

  wire            grant   = inta & int_out;
  wire [NUM-1:0]  gnt_vec = grant ? (NUM'(1) << win_idx) : '0;
  wire [NUM-1:0]  eoi_vec = (eoi_stb && srv_vld) ? (NUM'(1) << srv_idx) : '0;
  wire [NUM-1:0]  irr_nxt = (mode & irq & ~gnt_vec) | (~mode & ((irr & ~gnt_vec) | rise));
  wire [IW-1:0]   ack_idx = int_out ? win_idx : {IW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irr   <= '0;
      isr   <= '0;
      mask  <= '1;
      mode  <= '0;
      irq_q <= '0;
      base  <= '0;
      wr_q  <= 1'b0;
    end else begin
      irq_q <= irq;
      wr_q  <= wr_act;
      irr   <= irr_nxt;
      isr   <= (isr & ~eoi_vec) | gnt_vec;
      if (wr_stb && addr == 2'd0) mask <= data_in[NUM-1:0];
      if (wr_stb && addr == 2'd1) base <= data_in[DW-1:IW];
      if (wr_stb && addr == 2'd3) mode <= data_in[NUM-1:0];
    end
  end

  always_comb begin
    data_out = '0;
    data_oe  = 1'b0;
    if (inta) begin
      data_out = {base, ack_idx};
      data_oe  = 1'b1;
    end else if (rd_act) begin
      data_oe = 1'b1;
      case (addr)
        2'd0:    data_out = DW'(irr);
        2'd1:    data_out = DW'(isr);
        2'd2:    data_out = DW'(mask);
        default: data_out = DW'(mode);
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cs_n,
  input logic           inta,
  input logic           int_out,
  input logic           data_oe,
  input logic           eoi_stb,
  input logic [NUM-1:0] irr,
  input logic [NUM-1:0] isr,
  input logic [NUM-1:0] mask
);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (irr == '0 && isr == '0 && mask == '1));

  a_r6_grant_adds_level: assert property (@(posedge clk) disable iff (rst)
    (inta && int_out && !eoi_stb) |=> $countones(isr) == $past($countones(isr)) + 1);

  a_r7_top_level_blocks: assert property (@(posedge clk) disable iff (rst)
    isr[0] |-> !int_out);

  a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_stb && !inta && isr != '0) |=> $countones(isr) + 1 == $past($countones(isr)));

  a_r10_spurious_no_change: assert property (@(posedge clk) disable iff (rst)
    (inta && !int_out && !eoi_stb) |=> $stable(isr));

  a_r9_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !inta) |-> !data_oe);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM(NUM)) chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .inta(inta), .int_out(int_out),
  .data_oe(data_oe), .eoi_stb(eoi_stb), .irr(irr), .isr(isr), .mask(mask)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       inta = 1'b0;
  logic       int_out;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq(irq), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .inta(inta), .int_out(int_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    irq = '0; inta = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; data_in = d; cs_n = 1'b0; wr_n = 1'b0;
    step();
    cs_n = 1'b1; wr_n = 1'b1;
    step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 d = data_out;
    cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  task automatic ack(output logic [7:0] v);
    inta = 1'b1;
    #1 v = data_out;
    step();
    inta = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    rd(2'd0, rv); check("R1 pending", rv, 8'h00);
    rd(2'd1, rv); check("R1 in-service", rv, 8'h00);
    rd(2'd2, rv); check("R1 mask", rv, 8'hFF);
    rd(2'd3, rv); check("R1 mode", rv, 8'h00);
  endtask

  task automatic t_mask_edge();
    do_reset();
    irq[4] = 1'b1; step();
    irq[4] = 1'b0; step();
    rd(2'd0, rv); check("R2 edge latched", rv, 8'h10);
    check("R4 masked no int", {7'd0, int_out}, 8'h00);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; data_in = 8'h00; step(); wr_n = 1'b1; step();
    rd(2'd2, rv); check("R9 cs_n high write ignored", rv, 8'hFF);
    wr(2'd0, 8'h00);
    check("R4 unmask raises int", {7'd0, int_out}, 8'h01);
    ack(rv); check("R6 vector base 0 level 4", rv, 8'h04);
    irq[1] = 1'b1; step();
    ack(rv); check("R6 vector level 1", rv, 8'h01);
    rd(2'd0, rv); check("R2 held line no retrigger", rv, 8'h00);
    rd(2'd1, rv); check("R6 in-service 1 and 4", rv, 8'h12);
    wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    check("R2 held line quiet after eoi", {7'd0, int_out}, 8'h00);
    irq = '0;
  endtask

  task automatic t_level();
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h08);
    rd(2'd3, rv); check("R9 mode readback", rv, 8'h08);
    irq[3] = 1'b1; step();
    rd(2'd0, rv); check("R3 level follows high", rv, 8'h08);
    check("R3 int high", {7'd0, int_out}, 8'h01);
    irq[3] = 1'b0; step();
    rd(2'd0, rv); check("R3 level withdrawn", rv, 8'h00);
    check("R3 int low", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_priority();
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hA8);
    irq[5] = 1'b1; irq[2] = 1'b1; step();
    irq = '0;
    ack(rv); check("R5 lower index wins", rv, 8'hAA);
    check("R7 lower level blocked", {7'd0, int_out}, 8'h00);
    irq[0] = 1'b1; step(); irq[0] = 1'b0;
    check("R7 higher level interrupts", {7'd0, int_out}, 8'h01);
    ack(rv); check("R6 nested vector", rv, 8'hA8);
    rd(2'd1, rv); check("R6 in-service nested", rv, 8'h05);
    addr = 2'd2; cs_n = 1'b0; wr_n = 1'b0;
    step(); step(); step();
    cs_n = 1'b1; wr_n = 1'b1; step();
    rd(2'd1, rv); check("R9 long strobe one eoi", rv, 8'h04);
    wr(2'd2, 8'h00);
    rd(2'd1, rv); check("R8 eoi empties", rv, 8'h00);
    check("R7 pending 5 now raises", {7'd0, int_out}, 8'h01);
    ack(rv); check("R5 remaining level 5", rv, 8'hAD);
  endtask

  task automatic t_spurious();
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    ack(rv); check("R10 spurious vector", rv, 8'h47);
    rd(2'd1, rv); check("R10 in-service unchanged", rv, 8'h00);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(2'd0, 8'h00);
    irq[2] = 1'b1; step();
    irq[2] = 1'b0; step();
    irq[2] = 1'b1; inta = 1'b1;
    #1 rv = data_out;
    check("R11 grant vector", rv, 8'h02);
    step(); inta = 1'b0; #1;
    rd(2'd0, rv); check("R11 new edge kept pending", rv, 8'h04);
    rd(2'd1, rv); check("R11 level in service", rv, 8'h04);
    check("R11 equal level blocked", {7'd0, int_out}, 8'h00);
    irq = '0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mask_edge();
    t_level();
    t_priority();
    t_spurious();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule